// File: doc/BRIEF.md
# Nonvolatile Shadow Store and Recall Sequencer

This block sits beside a byte-wide working memory and keeps a same-sized nonvolatile shadow copy of it. A store moves every working byte into the shadow. It does this in two walks over the addresses: the first wipes the shadow to the erased value (all ones), and the second programs it from the working memory. A recall also takes two walks: the first zeroes the working memory, and the second loads it from the shadow. The shadow is left unchanged, so a recall can be repeated as often as needed. Both arrays are modelled as clocked register memories. Each walk advances one address per clock.

Four sources can ask for work. A software command detector can ask for a store or a recall. A power-fail monitor asks for an automatic store. A supply monitor drives a level that is high while the supply is above its sense threshold. While that level is low, a recall is latched. The recall begins once the level is high again, and this also covers power-up. The block keeps a modified flag. An automatic store runs only if some host write was taken since the last store or recall finished. A software store always runs. While a walk runs, host accesses are refused. Requests that arrive during a walk are queued, and a queued recall wins over a queued store.

The host port is synchronous. A read returns data on the clock after it is presented. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `nvs_shadow_ctrl`

## Requirements
- R1: After reset, `busy`, `dirty`, `write_corrupt` and `host_rdata` are all 0.
- R2: While `busy` is low, a host write (`host_en`=1, `host_we`=1) stores `host_wdata` at `host_addr`. A host read (`host_en`=1, `host_we`=0) presents that byte on `host_rdata` one clock later.
- R3: `dirty` rises on the clock after a write is accepted. It is 0 once any store or recall has finished.
- R4: A software store always runs, even with `dirty` at 0. `busy` then stays high for exactly 2*DEPTH clocks, and afterwards the shadow holds the working memory contents.
- R5: A `pwr_fail` pulse while `dirty` is 0 starts no cycle, and `busy` stays low. With `dirty` at 1, it runs a full store of 2*DEPTH clocks.
- R6: A recall leaves the working memory equal to the shadow. It does not change the shadow, so a second recall gives the same data after the working memory has been changed.
- R7: While `supply_ok` is low, no cycle starts and a recall is latched. On the first clock where `supply_ok` is high, that recall starts.
- R8: While `busy` is high, host writes are dropped and `host_rdata` holds its value.
- R9: Requests arriving while busy, or together with another request, are queued. They are served one after another with a single idle clock between them, and a queued recall runs before a queued store.
- R10: A host write presented in the last clock of a supply-triggered recall is dropped. It raises `write_corrupt` for exactly one clock, on the clock after that last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host access is a write when 1 |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| sw_store_req | input | 1 | One-clock software store request |
| sw_recall_req | input | 1 | One-clock software recall request |
| pwr_fail | input | 1 | One-clock automatic store request on power loss |
| supply_ok | input | 1 | High while the supply is above its threshold |
| busy | output | 1 | A store or recall walk is in progress |
| dirty | output | 1 | A write was taken since the last store or recall |
| write_corrupt | output | 1 | One-clock flag for a write at the end of a supply recall |

## Verification
The checker assumes that request inputs are single-clock pulses and that `supply_ok` never falls in the middle of a walk. Under those assumptions every busy run is exactly one store or one recall of 2*DEPTH clocks. The bench drops `supply_ok` only while the block is idle, and it times injected writes by counting busy clocks from the start of a walk. Random host traffic is issued only while `busy` is low, with addresses and data drawn from a fixed seed. Writes aimed at busy windows come only from directed cases.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ERASE = 3'd1,
    PH_PROG  = 3'd2,
    PH_CLEAR = 3'd3,
    PH_COPY  = 3'd4
  } phase_t;
endpackage

// File: rtl/nvs_array.sv
// Register-file memory: one clocked write port, one combinational read port.
module nvs_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/nvs_seq.sv
// Request queue, walk sequencer and modified-flag tracking.
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_store,
  input  logic              sw_recall,
  input  logic              pwr_fail,
  input  logic              supply_ok,
  input  logic              host_wr_ok,
  output phase_t            phase,
  output logic [ADDR_W-1:0] step_addr,
  output logic              last_step,
  output logic              hw_recall,
  output logic              dirty
);
  phase_t            phase_q, phase_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              sw_st_q, sw_st_d;
  logic              au_st_q, au_st_d;
  logic              rec_q, rec_d;
  logic              rec_hw_q, rec_hw_d;
  logic              hw_cur_q, hw_cur_d;
  logic              dirty_q, dirty_d;
  logic              cnt_en;

  assign last_step = &cnt_q;
  assign cnt_en    = (phase_q != PH_IDLE) || (phase_d != PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    hw_cur_d = hw_cur_q;
    sw_st_d  = sw_st_q | sw_store;
    au_st_d  = au_st_q | pwr_fail;
    rec_d    = rec_q | sw_recall | ~supply_ok;
    rec_hw_d = rec_hw_q | ~supply_ok;
    dirty_d  = dirty_q | host_wr_ok;
    unique case (phase_q)
      PH_IDLE: begin
        if (supply_ok) begin
          if (rec_d) begin
            phase_d  = PH_CLEAR;
            cnt_d    = '0;
            hw_cur_d = rec_hw_d;
            rec_d    = 1'b0;
            rec_hw_d = 1'b0;
          end else if (sw_st_d || (au_st_d && (dirty_q || host_wr_ok))) begin
            phase_d = PH_ERASE;
            cnt_d   = '0;
            sw_st_d = 1'b0;
            au_st_d = 1'b0;
          end else begin
            au_st_d = 1'b0;
          end
        end
      end
      PH_ERASE: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) phase_d = PH_PROG;
      end
      PH_PROG: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) begin
          phase_d = PH_IDLE;
          dirty_d = 1'b0;
        end
      end
      PH_CLEAR: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) phase_d = PH_COPY;
      end
      PH_COPY: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) begin
          phase_d = PH_IDLE;
          dirty_d = 1'b0;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      sw_st_q  <= 1'b0;
      au_st_q  <= 1'b0;
      rec_q    <= 1'b0;
      rec_hw_q <= 1'b0;
      hw_cur_q <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
      sw_st_q  <= sw_st_d;
      au_st_q  <= au_st_d;
      rec_q    <= rec_d;
      rec_hw_q <= rec_hw_d;
      hw_cur_q <= hw_cur_d;
      dirty_q  <= dirty_d;
    end
  end

  assign phase     = phase_q;
  assign step_addr = cnt_q;
  assign hw_recall = hw_cur_q;
  assign dirty     = dirty_q;
endmodule

// File: rtl/nvs_shadow_ctrl.sv
module nvs_shadow_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              sw_store_req,
  input  logic              sw_recall_req,
  input  logic              pwr_fail,
  input  logic              supply_ok,
  output logic              busy,
  output logic              dirty,
  output logic              write_corrupt
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sn;
  phase_t            phase;
  logic [ADDR_W-1:0] step_addr;
  logic              last_step, hw_recall;
  logic              host_wr_ok, host_rd_ok;
  logic              sram_we, nv_we;
  logic [ADDR_W-1:0] sram_waddr, sram_raddr;
  logic [DATA_W-1:0] sram_wdata, sram_rdata, nv_wdata, nv_rdata;
  logic [DATA_W-1:0] rdata_q;
  logic              corrupt_q, corrupt_d;

  // Reset asserts at once, releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  assign busy       = (phase != PH_IDLE);
  assign host_wr_ok = host_en & host_we & ~busy;
  assign host_rd_ok = host_en & ~host_we & ~busy;

  nvs_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .sw_store   (sw_store_req),
    .sw_recall  (sw_recall_req),
    .pwr_fail   (pwr_fail),
    .supply_ok  (supply_ok),
    .host_wr_ok (host_wr_ok),
    .phase      (phase),
    .step_addr  (step_addr),
    .last_step  (last_step),
    .hw_recall  (hw_recall),
    .dirty      (dirty)
  );

  always_comb begin
    sram_we    = host_wr_ok || (phase == PH_CLEAR) || (phase == PH_COPY);
    sram_waddr = busy ? step_addr : host_addr;
    sram_raddr = busy ? step_addr : host_addr;
    if (phase == PH_CLEAR)     sram_wdata = '0;
    else if (phase == PH_COPY) sram_wdata = nv_rdata;
    else                       sram_wdata = host_wdata;
    nv_we    = (phase == PH_ERASE) || (phase == PH_PROG);
    nv_wdata = (phase == PH_ERASE) ? '1 : sram_rdata;
    corrupt_d = (phase == PH_COPY) && last_step && hw_recall && host_en && host_we;
  end

  nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
    .clk   (clk),
    .we    (sram_we),
    .waddr (sram_waddr),
    .wdata (sram_wdata),
    .raddr (sram_raddr),
    .rdata (sram_rdata)
  );

  nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk   (clk),
    .we    (nv_we),
    .waddr (step_addr),
    .wdata (nv_wdata),
    .raddr (step_addr),
    .rdata (nv_rdata)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rdata_q   <= '0;
      corrupt_q <= 1'b0;
    end else begin
      if (host_rd_ok) rdata_q <= sram_rdata;
      corrupt_q <= corrupt_d;
    end
  end

  assign host_rdata    = rdata_q;
  assign write_corrupt = corrupt_q;
endmodule

// File: rtl/nvs_shadow_ctrl_chk.sv
module nvs_shadow_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_en,
  input logic              host_we,
  input logic [DATA_W-1:0] host_rdata,
  input logic              supply_ok,
  input logic              busy,
  input logic              dirty,
  input logic              write_corrupt
);
  localparam int RUN_LEN = 2 << ADDR_W;

  logic [ADDR_W+1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUN_LEN[ADDR_W+1:0]));

  assert_dirty_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && host_we && !busy) |=> dirty);

  assert_dirty_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !dirty);

  assert_no_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !busy) |=> !busy);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(host_rdata));

  assert_corrupt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    write_corrupt |=> !write_corrupt);

  assert_corrupt_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    write_corrupt |-> ($past(busy) && !busy));
endmodule

bind nvs_shadow_ctrl nvs_shadow_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sn),
  .host_en       (host_en),
  .host_we       (host_we),
  .host_rdata    (host_rdata),
  .supply_ok     (supply_ok),
  .busy          (busy),
  .dirty         (dirty),
  .write_corrupt (write_corrupt)
);

// File: tb/nvs_shadow_ctrl_test.sv
`timescale 1ns/1ps
module nvs_shadow_ctrl_test;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int RUN   = 2 * DEPTH;

  logic          clk, rst_n;
  logic          host_en, host_we;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic          sw_store_req, sw_recall_req, pwr_fail, supply_ok;
  logic          busy, dirty, write_corrupt;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] m_sram [DEPTH];
  logic [DW-1:0] m_nv   [DEPTH];

  nvs_shadow_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
    .pwr_fail(pwr_fail), .supply_ok(supply_ok), .busy(busy),
    .dirty(dirty), .write_corrupt(write_corrupt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] pattern(input int a, input int salt);
    return DW'((a * 37 + salt * 11 + 5) ^ (salt << 2));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    host_en = 1; host_we = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
    m_sram[a] = d;
  endtask

  task automatic rd_chk(input int a, input logic [DW-1:0] exp, input string req);
    host_en = 1; host_we = 0; host_addr = AW'(a);
    @(negedge clk);
    host_en = 0;
    chk(host_rdata == exp, req, host_rdata, exp);
  endtask

  // Counts busy clocks; optionally presents a write during busy clock number inj.
  task automatic run(input int inj, input int ia, input logic [DW-1:0] id, output int n);
    n = 0;
    while (busy && n < 4 * RUN) begin
      n++;
      if (n == inj) begin
        host_en = 1; host_we = 1; host_addr = AW'(ia); host_wdata = id;
      end else begin
        host_en = 0; host_we = 0;
      end
      @(negedge clk);
    end
    host_en = 0; host_we = 0;
  endtask

  task automatic do_store_model();
    for (int i = 0; i < DEPTH; i++) m_nv[i] = m_sram[i];
  endtask

  task automatic do_recall_model();
    for (int i = 0; i < DEPTH; i++) m_sram[i] = m_nv[i];
  endtask

  task automatic check_all_sram(input string req);
    for (int i = 0; i < DEPTH; i++) rd_chk(i, m_sram[i], req);
  endtask

  initial begin
    int n;
    logic [DW-1:0] held, bad;
    void'($urandom(32'd4411));
    rst_n = 0; host_en = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    sw_store_req = 0; sw_recall_req = 0; pwr_fail = 0; supply_ok = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(dirty == 0, "R1 dirty", dirty, 0);
    chk(write_corrupt == 0, "R1 write_corrupt", write_corrupt, 0);
    chk(host_rdata == 0, "R1 rdata", host_rdata, 0);

    // R2, R3: fill, then random mix of accesses
    for (int i = 0; i < DEPTH; i++) wr(i, pattern(i, 1));
    chk(dirty == 1, "R3 dirty after write", dirty, 1);
    for (int k = 0; k < 60; k++) begin
      int a = int'($urandom_range(DEPTH - 1));
      if ($urandom_range(1) == 1) wr(a, DW'($urandom));
      else rd_chk(a, m_sram[a], "R2 random read");
    end
    rd_chk(DEPTH - 1, m_sram[DEPTH-1], "R2 top address");

    // R4, R8: software store, with a write and read held off mid-walk
    held = host_rdata;
    sw_store_req = 1; @(negedge clk); sw_store_req = 0;
    chk(busy == 1, "R4 busy start", busy, 1);
    bad = ~m_sram[2];
    run(5, 2, bad, n);
    chk(n == RUN, "R4 busy length", n, RUN);
    chk(host_rdata == held, "R8 rdata held", host_rdata, held);
    chk(dirty == 0, "R3 dirty cleared by store", dirty, 0);
    do_store_model();
    rd_chk(2, m_sram[2], "R8 busy write dropped");

    // R4: software store with dirty at 0 still runs
    sw_store_req = 1; @(negedge clk); sw_store_req = 0;
    run(0, 0, 0, n);
    chk(n == RUN, "R4 clean software store", n, RUN);

    // R5: automatic store skipped when clean
    pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    chk(busy == 0, "R5 clean auto store skipped", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R5 still idle", busy, 0);

    // R5: automatic store taken when dirty
    for (int i = 0; i < DEPTH; i += 3) wr(i, pattern(i, 2));
    pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    run(0, 0, 0, n);
    chk(n == RUN, "R5 dirty auto store", n, RUN);
    do_store_model();

    // R6: recall twice after changing the working memory
    for (int i = 0; i < DEPTH; i++) wr(i, pattern(i, 3));
    sw_recall_req = 1; @(negedge clk); sw_recall_req = 0;
    run(0, 0, 0, n);
    chk(n == RUN, "R6 recall length", n, RUN);
    chk(dirty == 0, "R3 dirty cleared by recall", dirty, 0);
    do_recall_model();
    check_all_sram("R6 recall data");
    for (int i = 0; i < DEPTH; i += 2) wr(i, pattern(i, 4));
    sw_recall_req = 1; @(negedge clk); sw_recall_req = 0;
    run(0, 0, 0, n);
    do_recall_model();
    check_all_sram("R6 repeated recall");

    // R9: store and recall requested together; recall must go first
    for (int i = 0; i < DEPTH; i++) wr(i, pattern(i, 5));
    sw_store_req = 1; sw_recall_req = 1; @(negedge clk);
    sw_store_req = 0; sw_recall_req = 0;
    run(0, 0, 0, n);
    chk(n == RUN, "R9 first walk", n, RUN);
    chk(busy == 0, "R9 idle gap", busy, 0);
    @(negedge clk);
    chk(busy == 1, "R9 queued walk starts", busy, 1);
    run(0, 0, 0, n);
    chk(n == RUN, "R9 second walk", n, RUN);
    do_recall_model();
    do_store_model();
    check_all_sram("R9 recall before store");

    // R9: request during a walk is queued
    sw_store_req = 1; @(negedge clk); sw_store_req = 0;
    repeat (4) @(negedge clk);
    sw_recall_req = 1; @(negedge clk); sw_recall_req = 0;
    run(0, 0, 0, n);
    @(negedge clk);
    chk(busy == 1, "R9 queued recall after store", busy, 1);
    run(0, 0, 0, n);
    chk(n == RUN, "R9 queued recall length", n, RUN);

    // R7, R10: supply dip latches recall; write at its last clock corrupts
    for (int i = 0; i < DEPTH; i++) wr(i, pattern(i, 6));
    supply_ok = 0;
    repeat (4) @(negedge clk);
    chk(busy == 0, "R7 no start while supply low", busy, 0);
    supply_ok = 1;
    @(negedge clk);
    chk(busy == 1, "R7 recall on supply return", busy, 1);
    bad = ~m_nv[3];
    run(RUN, 3, bad, n);
    chk(n == RUN, "R7 recall length", n, RUN);
    chk(write_corrupt == 1, "R10 corrupt flag", write_corrupt, 1);
    @(negedge clk);
    chk(write_corrupt == 0, "R10 flag one clock", write_corrupt, 0);
    do_recall_model();
    rd_chk(3, m_nv[3], "R10 write dropped");
    check_all_sram("R7 recall data");

    // R10: software recall does not flag a write at its end
    sw_recall_req = 1; @(negedge clk); sw_recall_req = 0;
    run(RUN, 5, ~m_nv[5], n);
    chk(write_corrupt == 0, "R10 no flag on software recall", write_corrupt, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule